// File: doc/BRIEF.md
# Differential Phase Bit Decoder with Self-Synchronizing Descrambler

This block turns a stream of quantized carrier phases, one 2-bit quadrant code per symbol, into a serial stream of data bits. For each symbol it takes the phase change from the symbol before it. In the quaternary mode that change selects a pair of bits. In the binary mode it selects a single bit. The bits leave one at a time, with the first-in-time bit of each pair first. They then pass through a self-synchronizing descrambler built on a 7-stage shift register of received bits.

The quadrant code counts counterclockwise steps of 90 degrees: 0 is 0°, 1 is +90°, 2 is 180° and 3 is +270° (that is, -90°). The phase change is (current - previous) mod 4. A rotation-reverse control negates that change, mod 4, before the lookup. The first symbol after reset only sets the reference phase and yields no bits. The mode and rotation-reverse inputs are sampled with each accepted symbol.

Both data edges use valid/ready. A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both high. `sym_ready` is high when no bit is pending, or when exactly one bit is pending and it leaves in the same cycle. A bit is taken on an edge where `bit_valid` and `bit_ready` are both high. While `bit_ready` is low, `bit_valid` and `bit_data` hold their values. The bits of an accepted symbol appear from the next cycle onward. They are not buffered beyond the current symbol.

Top module: `dpsk_bitdec`

## Requirements
- R1: After reset, `bit_valid` is 0 and `sym_ready` is 1.
- R2: The first symbol accepted after reset produces no output bit. It only becomes the phase reference.
- R3: In quaternary mode, a change of 0 produces bits 00, +90° produces 01, 180° produces 11, and -90° produces 10 (written first-bit, second-bit), before descrambling.
- R4: In quaternary mode, the first bit of each pair leaves before the second, in consecutive handshakes.
- R5: With `rot_rev` = 1, the phase change is negated mod 4 before the lookup, so a code step of +1 decodes as 10 and a code step of +3 decodes as 01.
- R6: In binary mode, each symbol yields one bit, equal to bit 1 of the phase change: no change gives 0 and 180° gives 1.
- R7: Each output bit is the raw decoded bit XOR the raw bits 4 and 7 positions earlier in the output order. The register holding those bits starts at zero after reset and advances only on an output handshake. A stream scrambled with x^7+x^4+1 from a zero state is therefore recovered exactly.
- R8: While `bit_ready` is 0, `bit_valid` stays 1 and `bit_data` holds its value. No new symbol is accepted while two bits are pending.
- R9: A new symbol is accepted in the same cycle as the last pending bit leaves, so binary mode sustains one bit per cycle.
- R10: One corrupted phase corrupts only the two symbol decisions that depend on it. The output is correct again once seven further correct bits have passed through the descrambler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Phase symbol offered |
| sym_ready | output | 1 | Symbol can be taken this cycle |
| sym_phase | input | 2 | Quadrant code, counterclockwise steps of 90° |
| mode_quat | input | 1 | 1: two bits per symbol, 0: one bit per symbol |
| rot_rev | input | 1 | 1: reverse the sense of rotation |
| bit_valid | output | 1 | Output bit offered |
| bit_ready | input | 1 | Sink takes the bit this cycle |
| bit_data | output | 1 | Descrambled output bit |

## Verification
Two events can land on the same edge: the last pending bit draining to the sink, and a new symbol being accepted that reloads the bit buffer. The bench provokes this with a continuous binary-mode stream and an always-ready sink. It checks that `sym_ready` stays high on every cycle and that the output sequence matches a scrambled reference with no bit lost or repeated. A stall test with `bit_ready` held low covers the opposite case. There, the symbol must wait and the offered bit must stay frozen.

// File: rtl/dpsk_dec_pkg.sv
package dpsk_dec_pkg;
  localparam int QUAD_W = 2;
  typedef logic [QUAD_W-1:0] quad_t;

  // Map phase change in quadrants to bit pair {first, second}
  function automatic logic [1:0] quad_to_pair(input quad_t d);
    logic [1:0] p;
    case (d)
      2'd0:    p = 2'b00;
      2'd1:    p = 2'b01;
      2'd2:    p = 2'b11;
      default: p = 2'b10;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dpsk_phase_diff.sv
module dpsk_phase_diff
  import dpsk_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  quad_t      phase,
  input  logic       quat,
  input  logic       rev,
  output logic [1:0] nbits,
  output logic [1:0] bits
);
  quad_t ref_q;
  logic  primed;
  quad_t delta_raw, delta;

  always_comb begin
    delta_raw = phase - ref_q;
    delta     = rev ? quad_t'(2'd0 - delta_raw) : delta_raw;
    if (!primed) begin
      nbits = 2'd0;
      bits  = 2'b00;
    end else if (quat) begin
      nbits = 2'd2;
      bits  = quad_to_pair(delta);
    end else begin
      nbits = 2'd1;
      bits  = {delta[1], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      primed <= 1'b0;
    end else if (take) begin
      ref_q  <= phase;
      primed <= 1'b1;
    end
  end

  AST_FIRST_PRIMES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !primed) |=> primed); // R2
endmodule

// File: rtl/dpsk_bit_serializer.sv
module dpsk_bit_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] nbits,
  input  logic [1:0] bits,
  output logic       can_push,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       head
);
  logic [1:0] cnt;
  logic [1:0] pend;
  logic       pop;

  assign out_valid = (cnt != 2'd0);
  assign head      = pend[1];
  assign pop       = out_valid && out_ready;
  assign can_push  = (cnt == 2'd0) || (cnt == 2'd1 && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= 2'd0;
      pend <= 2'b00;
    end else if (push) begin
      cnt  <= nbits;
      pend <= bits;
    end else if (pop) begin
      cnt  <= cnt - 2'd1;
      pend <= {pend[0], 1'b0};
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(head))); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2) |-> !can_push); // R8
  AST_BIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && nbits == 2'd1) |=> (cnt == 2'd1)); // R6
  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == 2'd2) |=> out_valid); // R4
endmodule

// File: rtl/dpsk_descrambler.sv
module dpsk_descrambler #(
  parameter int SR_LEN   = 7,
  parameter int TAP_NEAR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic raw,
  output logic clear
);
  localparam int NEAR_IX = TAP_NEAR - 1;
  localparam int FAR_IX  = SR_LEN - 1;

  logic [SR_LEN-1:0] hist;

  assign clear = raw ^ hist[NEAR_IX] ^ hist[FAR_IX];

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (adv) hist <= {hist[SR_LEN-2:0], raw};
  end

  AST_SR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (hist[0] == $past(raw))); // R7
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hist)); // R7
endmodule

// File: rtl/dpsk_bitdec.sv
module dpsk_bitdec
  import dpsk_dec_pkg::*;
#(
  parameter int SR_LEN   = 7,
  parameter int TAP_NEAR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [1:0] sym_phase,
  input  logic       mode_quat,
  input  logic       rot_rev,
  output logic       bit_valid,
  input  logic       bit_ready,
  output logic       bit_data
);
  logic       take, pop, raw;
  logic [1:0] nbits, bits;

  assign take = sym_valid && sym_ready;
  assign pop  = bit_valid && bit_ready;

  dpsk_phase_diff u_diff (
    .clk(clk), .rst_n(rst_n), .take(take), .phase(sym_phase),
    .quat(mode_quat), .rev(rot_rev), .nbits(nbits), .bits(bits)
  );

  dpsk_bit_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .push(take), .nbits(nbits), .bits(bits),
    .can_push(sym_ready), .out_valid(bit_valid), .out_ready(bit_ready),
    .head(raw)
  );

  dpsk_descrambler #(.SR_LEN(SR_LEN), .TAP_NEAR(TAP_NEAR)) u_desc (
    .clk(clk), .rst_n(rst_n), .adv(pop), .raw(raw), .clear(bit_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!bit_valid && sym_ready)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> $stable(bit_data)); // R8
endmodule

// File: tb/dpsk_bitdec_tb.sv
module dpsk_bitdec_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic sym_valid = 0, mode_quat = 0, rot_rev = 0, bit_ready = 1;
  logic [1:0] sym_phase = 0;
  logic sym_ready, bit_valid, bit_data;

  always #2 clk = ~clk;

  dpsk_bitdec u_dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_phase(sym_phase), .mode_quat(mode_quat), .rot_rev(rot_rev),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data)
  );

  int checks = 0, errors = 0;
  string tag = "R1";

  // bench reference state
  logic       m_primed;
  logic [1:0] m_ref;
  logic [6:0] m_hist;
  logic       exp_q[$];
  logic       e2e_q[$];
  bit         e2e_on;
  int         e2e_idx, e2e_from, e2e_bad;

  task automatic check(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  task automatic model_take(input logic [1:0] q, input logic quat, input logic rev);
    logic [1:0] d;
    logic [1:0] p;
    int n;
    if (!m_primed) begin
      m_primed = 1; m_ref = q; return;
    end
    d = q - m_ref;
    if (rev) d = 2'd0 - d;
    m_ref = q;
    if (quat) begin
      case (d) 2'd0: p = 2'b00; 2'd1: p = 2'b01; 2'd2: p = 2'b11; default: p = 2'b10; endcase
      n = 2;
    end else begin
      p = {d[1], 1'b0}; n = 1;
    end
    for (int i = 0; i < n; i++) begin
      logic r;
      r = p[1-i];
      exp_q.push_back(r ^ m_hist[3] ^ m_hist[6]);
      m_hist = {m_hist[5:0], r};
    end
  endtask

  task automatic cyc(input logic v, input logic [1:0] q, input logic quat,
                     input logic rev, input logic ordy, output logic took);
    @(negedge clk);
    sym_valid = v; sym_phase = q; mode_quat = quat; rot_rev = rev; bit_ready = ordy;
    #1;
    took = v && sym_ready;
    if (bit_valid && bit_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual=unexpected bit expected=none", tag);
      end else check(tag, bit_data, exp_q.pop_front());
      if (e2e_on && e2e_q.size() != 0) begin
        logic e;
        e = e2e_q.pop_front();
        if (e2e_idx >= e2e_from) check(tag, bit_data, e);
        else if (bit_data !== e) e2e_bad++;
        e2e_idx++;
      end
    end
    if (took) model_take(q, quat, rev);
  endtask

  task automatic send(input logic [1:0] q, input logic quat, input logic rev);
    logic t;
    t = 0;
    while (!t) cyc(1, q, quat, rev, 1, t);
  endtask

  task automatic drain();
    logic t;
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, t);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s actual=%0d bits missing expected=0", tag, exp_q.size());
    end
    exp_q.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sym_valid = 0; bit_ready = 1;
    m_primed = 0; m_ref = 0; m_hist = 0;
    exp_q.delete(); e2e_q.delete(); e2e_on = 0; e2e_idx = 0; e2e_from = 0; e2e_bad = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    tag = "R1";
    do_reset();
    #1;
    check("R1 bit_valid", bit_valid, 1'b0);
    check("R1 sym_ready", sym_ready, 1'b1);
  endtask

  task automatic t_first();
    logic t;
    tag = "R2";
    do_reset();
    send(2'd3, 1, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 1, t);
      check("R2 no output after reference", bit_valid, 1'b0);
    end
  endtask

  task automatic t_quat();
    logic [1:0] ph;
    logic t;
    tag = "R3";
    do_reset();
    ph = 0;
    send(ph, 1, 0);
    // steps 0,+1,+2,+3 with hist at zero: first pair raw == output
    ph = ph + 1; send(ph, 1, 0);
    cyc(0, 0, 0, 0, 1, t);
    check("R4 first bit of +90 pair", bit_data, 1'b0);
    cyc(0, 0, 0, 0, 1, t);
    check("R4 second bit of +90 pair", bit_data, 1'b1);
    for (int s = 0; s < 4; s++) begin
      ph = ph + 2'(s); send(ph, 1, 0);
      ph = ph + 2'(3 - s); send(ph, 1, 0);
    end
    drain();
  endtask

  task automatic t_rev();
    logic [1:0] ph;
    tag = "R5";
    do_reset();
    ph = 1;
    send(ph, 1, 1);
    for (int s = 0; s < 8; s++) begin
      ph = ph + 2'(s % 4);
      send(ph, 1, 1);
    end
    drain();
  endtask

  task automatic t_bin();
    logic [1:0] ph;
    tag = "R6";
    do_reset();
    ph = 2;
    send(ph, 0, 0);
    for (int s = 0; s < 12; s++) begin
      ph = ph + 2'((s * 3 + 1) % 4);
      send(ph, 0, s[0]);
    end
    drain();
  endtask

  // scramble data with x^7+x^4+1, encode as phases, expect data back
  task automatic t_e2e(input string tg, input logic quat, input int nsym, input int bad_sym);
    logic [6:0] sh;
    logic [15:0] lf;
    logic [1:0] ph;
    tag = tg;
    do_reset();
    e2e_on = 1;
    e2e_from = (bad_sym < 0) ? 0 : (bad_sym + 2) * (quat ? 2 : 1) + 7;
    sh = 0; lf = 16'hACE1; ph = 0;
    send(ph, quat, 0);
    for (int s = 0; s < nsym; s++) begin
      logic [1:0] sb;
      logic [1:0] d;
      for (int k = 0; k < (quat ? 2 : 1); k++) begin
        logic db, sc;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        db = lf[0];
        sc = db ^ sh[3] ^ sh[6];
        sh = {sh[5:0], sc};
        sb[1-k] = sc;
        e2e_q.push_back(db);
      end
      if (quat) begin
        case (sb) 2'b00: d = 0; 2'b01: d = 1; 2'b11: d = 2; default: d = 3; endcase
      end else d = sb[1] ? 2'd2 : 2'd0;
      ph = ph + d;
      send((s == bad_sym) ? ph + 2'd1 : ph, quat, 0);
      if (s == bad_sym) ph = ph; // reference for encoding stays true
    end
    drain();
    if (bad_sym >= 0) begin
      checks++;
      if (e2e_bad == 0) begin
        errors++;
        $display("FAIL R10 actual=0 corrupted bits expected=nonzero");
      end
    end
  endtask

  task automatic t_stall();
    logic t;
    logic held;
    tag = "R8";
    do_reset();
    send(0, 1, 0);
    cyc(1, 2'd2, 1, 0, 0, t);            // accepted (no bits pending)
    for (int i = 0; i < 4; i++) begin
      cyc(1, 2'd3, 1, 0, 0, t);
      if (i == 0) held = bit_data;
      check("R8 valid held", bit_valid, 1'b1);
      check("R8 data held", bit_data, held);
      check("R8 no accept while two pending", t, 1'b0);
    end
    cyc(0, 0, 1, 0, 1, t);
    drain();
  endtask

  task automatic t_stream();
    logic t;
    logic [1:0] ph;
    tag = "R9";
    do_reset();
    ph = 0;
    send(ph, 0, 0);
    for (int s = 0; s < 20; s++) begin
      ph = ph + ((s % 3 == 0) ? 2'd2 : 2'd0);
      cyc(1, ph, 0, 0, 1, t);
      check("R9 accepted each cycle", t, 1'b1);
    end
    drain();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first();
    t_quat();
    t_rev();
    t_bin();
    t_e2e("R7", 1, 40, -1);
    t_e2e("R7", 0, 40, -1);
    t_stall();
    t_stream();
    t_e2e("R10", 1, 30, 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule